// File: doc/BRIEF.md
# Speculative Branch History Unit

This block tracks two shift registers for a neural-style branch predictor: a 40-bit record of branch directions and a 128-bit record of one low address bit per branch. Each record exists twice. A speculative copy advances as soon as the front end predicts a branch. A committed copy advances only when a branch retires with its real outcome.

The predictor does not read the 40-bit direction record directly. It reads a 128-bit vector built by redundant expansion. The 16 most recent directions are repeated four times, and the full 40-bit history then fills the remaining positions cyclically. Recent outcomes therefore carry more weight.

On a misprediction flush, both speculative copies are rebuilt in one cycle. The block takes the committed copy, including any commit arriving in that same cycle, and shifts in the corrected direction and address bit.

Top module: `spec_hist_unit`

## Requirements
- R1: While reset is asserted, `hist_vec` and `path_vec` are all zero, and so are both committed copies.
- R2: A prediction event without a flush shifts `pred_taken` into direction history bit 0 and `pred_addr_bit` into `path_vec[0]`. Every older bit moves up by one position, and the change is visible after the next rising clock edge.
- R3: A commit event alone leaves `hist_vec` and `path_vec` unchanged.
- R4: A flush loads the speculative direction history with the committed history shifted by `flush_taken`. It loads the speculative path with the committed path shifted by `flush_addr_bit`. Both take effect at the same clock edge.
- R5: When a commit and a flush arrive in the same cycle, the committed bit is shifted in first and the corrected bit is shifted in after it, in both rebuilt registers.
- R6: A flush takes priority over a prediction event in the same cycle, and that prediction's bits do not appear in either output.
- R7: Bit n of `hist_vec` equals direction history bit (n mod 16) for n < 64, and direction history bit ((n-64) mod 40) for n >= 64. History bit 0 is the newest direction, and 1 means taken.
- R8: The direction history holds exactly 40 outcomes and the path exactly 128 address bits. The oldest bit is dropped when a new one enters.
- R9: A prediction and a commit arriving in the same cycle are both applied: one to the speculative copies, the other to the committed copies.
- R10: With no event in a cycle, both outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_valid | input | 1 | A branch was predicted this cycle |
| pred_taken | input | 1 | Predicted direction, 1 = taken |
| pred_addr_bit | input | 1 | Low address bit of the predicted branch |
| commit_valid | input | 1 | A branch retired this cycle |
| commit_taken | input | 1 | Actual direction of the retired branch |
| commit_addr_bit | input | 1 | Low address bit of the retired branch |
| flush | input | 1 | Misprediction: rebuild the speculative state |
| flush_taken | input | 1 | Corrected direction of the mispredicted branch |
| flush_addr_bit | input | 1 | Low address bit of the mispredicted branch |
| hist_vec | output | 128 | Expanded direction history for the predictor |
| path_vec | output | 128 | Speculative path of address bits, bit 0 newest |

## Verification
A walking single taken bit is pushed through all 40 history positions. Each position's copies in the expanded vector are checked, which separates a wrong index mapping from a wrong shift. The path register is filled past its 128-bit depth to show that the oldest bit drops out. Directed cycles combine a flush with a same-cycle commit or prediction, which tells the ordering and priority rules apart. A long pseudo-random mix of all three events is then checked against a bench model every cycle.

// File: rtl/shu_pkg.sv
package shu_pkg;
   typedef enum logic [1:0] {
      UPD_HOLD  = 2'd0,
      UPD_SPEC  = 2'd1,
      UPD_FLUSH = 2'd2
   } upd_e;
endpackage

// File: rtl/shu_track.sv
module shu_track
   import shu_pkg::*;
#(
   parameter int W = 40
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         spec_v,
   input  logic         spec_b,
   input  logic         cmt_v,
   input  logic         cmt_b,
   input  logic         flush,
   input  logic         fix_b,
   output logic [W-1:0] spec_q
);
   logic [W-1:0] cmt_q, cmt_d, spec_d;
   upd_e         kind;

   always_comb begin
      cmt_d = cmt_v ? {cmt_q[W-2:0], cmt_b} : cmt_q;
      if (flush)       kind = UPD_FLUSH;
      else if (spec_v) kind = UPD_SPEC;
      else             kind = UPD_HOLD;
      case (kind)
         UPD_FLUSH: spec_d = {cmt_d[W-2:0], fix_b};
         UPD_SPEC:  spec_d = {spec_q[W-2:0], spec_b};
         default:   spec_d = spec_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmt_q  <= '0;
         spec_q <= '0;
      end else begin
         cmt_q  <= cmt_d;
         spec_q <= spec_d;
      end
   end
endmodule

// File: rtl/shu_expand.sv
module shu_expand #(
   parameter int HIST_W   = 40,
   parameter int VEC_W    = 128,
   parameter int RECENT_W = 16,
   parameter int COPIES   = 4
) (
   input  logic [HIST_W-1:0] hist,
   output logic [VEC_W-1:0]  vec
);
   localparam int REP_END = RECENT_W * COPIES;

   for (genvar i = 0; i < VEC_W; i++) begin : g_pos
      localparam int IDX = (i < REP_END) ? (i % RECENT_W) : ((i - REP_END) % HIST_W);
      assign vec[i] = hist[IDX];
   end
endmodule

// File: rtl/spec_hist_unit.sv
module spec_hist_unit #(
   parameter int HIST_W        = 40,
   parameter int VEC_W         = 128,
   parameter int PATH_W        = 128,
   parameter int RECENT_W      = 16,
   parameter int RECENT_COPIES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pred_valid,
   input  logic              pred_taken,
   input  logic              pred_addr_bit,
   input  logic              commit_valid,
   input  logic              commit_taken,
   input  logic              commit_addr_bit,
   input  logic              flush,
   input  logic              flush_taken,
   input  logic              flush_addr_bit,
   output logic [VEC_W-1:0]  hist_vec,
   output logic [PATH_W-1:0] path_vec
);
   if (HIST_W < 2 || PATH_W < 2) begin : g_bad_width
      $error("history and path widths must be at least 2");
   end
   if (RECENT_W > HIST_W) begin : g_bad_recent
      $error("recent window exceeds history width");
   end
   if (RECENT_W * RECENT_COPIES > VEC_W) begin : g_bad_copies
      $error("repeated recent bits exceed vector width");
   end

   logic [HIST_W-1:0] spec_hist;

   shu_track #(.W(HIST_W)) u_hist (
      .clk(clk), .rst_n(rst_n),
      .spec_v(pred_valid), .spec_b(pred_taken),
      .cmt_v(commit_valid), .cmt_b(commit_taken),
      .flush(flush), .fix_b(flush_taken),
      .spec_q(spec_hist)
   );

   shu_track #(.W(PATH_W)) u_path (
      .clk(clk), .rst_n(rst_n),
      .spec_v(pred_valid), .spec_b(pred_addr_bit),
      .cmt_v(commit_valid), .cmt_b(commit_addr_bit),
      .flush(flush), .fix_b(flush_addr_bit),
      .spec_q(path_vec)
   );

   shu_expand #(
      .HIST_W(HIST_W), .VEC_W(VEC_W),
      .RECENT_W(RECENT_W), .COPIES(RECENT_COPIES)
   ) u_exp (
      .hist(spec_hist),
      .vec(hist_vec)
   );
endmodule

// File: rtl/spec_hist_unit_chk.sv
module spec_hist_unit_chk #(
   parameter int VEC_W  = 128,
   parameter int PATH_W = 128
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pred_valid,
   input logic              pred_taken,
   input logic              pred_addr_bit,
   input logic              commit_valid,
   input logic              flush,
   input logic              flush_taken,
   input logic              flush_addr_bit,
   input logic [VEC_W-1:0]  hist_vec,
   input logic [PATH_W-1:0] path_vec
);
   // R2
   pred_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_valid && !flush) |=> (hist_vec[0] == $past(pred_taken)) && (path_vec[0] == $past(pred_addr_bit)));
   // R2
   path_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_valid && !flush) |=> path_vec[PATH_W-1:1] == $past(path_vec[PATH_W-2:0]));
   // R4
   flush_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (hist_vec[0] == $past(flush_taken)) && (path_vec[0] == $past(flush_addr_bit)));
   // R3
   commit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pred_valid && !flush && commit_valid) |=> $stable(hist_vec) && $stable(path_vec));
   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pred_valid && !flush && !commit_valid) |=> $stable(hist_vec) && $stable(path_vec));
endmodule

bind spec_hist_unit spec_hist_unit_chk #(.VEC_W(VEC_W), .PATH_W(PATH_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_addr_bit(pred_addr_bit),
   .commit_valid(commit_valid), .flush(flush),
   .flush_taken(flush_taken), .flush_addr_bit(flush_addr_bit),
   .hist_vec(hist_vec), .path_vec(path_vec)
);

// File: tb/spec_hist_unit_bench.sv
module spec_hist_unit_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pv = 0, pt = 0, pa = 0, cv = 0, ct = 0, ca = 0, fl = 0, ft = 0, fa = 0;
   logic [127:0] hist_vec, path_vec;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [39:0]  m_sh, m_ch;
   logic [127:0] m_sp, m_cp;

   always #2 clk = ~clk;

   spec_hist_unit u_spec_hist_unit (
      .clk(clk), .rst_n(rst_n),
      .pred_valid(pv), .pred_taken(pt), .pred_addr_bit(pa),
      .commit_valid(cv), .commit_taken(ct), .commit_addr_bit(ca),
      .flush(fl), .flush_taken(ft), .flush_addr_bit(fa),
      .hist_vec(hist_vec), .path_vec(path_vec)
   );

   function automatic logic [127:0] expand(input logic [39:0] h);
      logic [127:0] v;
      for (int n = 0; n < 128; n++)
         v[n] = (n < 64) ? h[n % 16] : h[(n - 64) % 40];
      return v;
   endfunction

   task automatic check_all(input string tag);
      logic [127:0] ev;
      ev = expand(m_sh);
      checks++;
      if (hist_vec !== ev) begin
         fails++;
         $display("FAIL %s hist_vec actual=%h expected=%h", tag, hist_vec, ev);
      end
      checks++;
      if (path_vec !== m_sp) begin
         fails++;
         $display("FAIL %s path_vec actual=%h expected=%h", tag, path_vec, m_sp);
      end
   endtask

   task automatic step(input logic ipv, ipt, ipa, icv, ict, ica, ifl, ift, ifa, input string tag);
      logic [39:0]  nch;
      logic [127:0] ncp;
      pv = ipv; pt = ipt; pa = ipa; cv = icv; ct = ict; ca = ica; fl = ifl; ft = ift; fa = ifa;
      @(posedge clk);
      #1;
      nch = icv ? {m_ch[38:0], ict} : m_ch;
      ncp = icv ? {m_cp[126:0], ica} : m_cp;
      if (ifl) begin
         m_sh = {nch[38:0], ift};
         m_sp = {ncp[126:0], ifa};
      end else if (ipv) begin
         m_sh = {m_sh[38:0], ipt};
         m_sp = {m_sp[126:0], ipa};
      end
      m_ch = nch;
      m_cp = ncp;
      pv = 0; cv = 0; fl = 0;
      check_all(tag);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      m_sh = '0; m_ch = '0; m_sp = '0; m_cp = '0;
      #9;
      check_all("R1 reset state");
      rst_n = 1'b1;
      #4;
      // R2: predictions
      for (int k = 0; k < 10; k++)
         step(1, k[0], k[1], 0, 0, 0, 0, 0, 0, "R2 prediction shift");
      // R3: commit alone
      for (int k = 0; k < 6; k++)
         step(0, 0, 0, 1, ~k[0], k[0], 0, 0, 0, "R3 commit only");
      // R10: idle
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 idle hold");
      // R9: prediction and commit together, then flush reveals commit copy
      for (int k = 0; k < 5; k++)
         step(1, 1, k[0], 1, k[1], ~k[0], 0, 0, 0, "R9 pred with commit");
      step(0, 0, 0, 0, 0, 0, 1, 1, 0, "R9 R4 flush after joint events");
      // R4: flush rebuilds from committed
      step(1, 1, 1, 0, 0, 0, 0, 0, 0, "R4 prep");
      step(0, 0, 0, 0, 0, 0, 1, 0, 1, "R4 flush reload");
      // R5: commit and flush same cycle
      step(0, 0, 0, 1, 1, 1, 1, 0, 0, "R5 commit with flush");
      // R6: flush beats prediction
      step(1, 1, 1, 0, 0, 0, 1, 0, 0, "R6 flush priority");
      // R8: history depth, drop of oldest
      for (int k = 0; k < 45; k++)
         step(1, (k == 0), 0, 0, 0, 0, 0, 0, 0, "R7 R8 walking taken bit");
      // R8: path depth
      step(1, 0, 1, 0, 0, 0, 0, 0, 0, "R8 path marker");
      for (int k = 0; k < 130; k++)
         step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R8 path drop oldest");
      // mixed pseudo-random sweep
      for (int k = 0; k < 3000; k++) begin
         logic [8:0] r;
         r = 9'($urandom);
         step(r[0], r[1], r[2], r[3], r[4], r[5], (r[8:6] == 3'd0), r[1] ^ r[4], r[2] ^ r[5],
              "R2 R4 R5 R6 R9 mixed");
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule